// File: doc/BRIEF.md
# Register File with Deferred-Fault Tracking

This block is the architectural integer register file of a pipeline that hoists loads and other operations above branches. Every register has a companion fault flag. An operation marked speculative in its encoding does not trap when it faults. Instead, the flag of its destination is raised and the fault waits there. The fault is reported only if a non-speculative operation later consumes that register. If the hoisted result is never used, because the branch went the other way, the fault disappears without a trace. Any later fault-free write to the register clears the flag.

The block has one write port and two read ports. The write port takes a destination index, the data, the speculative flag and a fault indication. It also takes a taint flag, which the pipeline carries from the read stage and which says that one of the operation's sources was flagged. Each read port returns data and flag combinationally. A write and a read of the same register in one cycle bypass the new data and flag to the reader.

A consume strobe says whether an instruction is using the read ports this cycle. It comes with the instruction's speculative flag and one use enable per source. From these the block raises a one-cycle deferred-exception pulse with the offending register index. It also raises a one-cycle immediate-trap pulse when a non-speculative write faults.

Top module: `poison_regfile`

## Requirements
- R1: After reset every register reads data 0 with its fault flag clear, and both exception pulses are low.
- R2: A speculative write with fault set stores its data and sets the destination's fault flag. No trap pulse follows.
- R3: A write without fault stores its data and clears the destination's fault flag. For a speculative write this also needs taint to be clear. The next cycle a read of that register returns the new data with the flag clear.
- R4: A speculative write with taint set and fault clear stores its data and sets the destination's fault flag. No exception pulse follows.
- R5: A non-speculative write with fault set changes no register. In the following cycle the trap pulse is high for exactly one cycle and the trap index equals the write's destination index.
- R6: A non-speculative consume of a flagged source with its use enable set gives a deferred pulse in the next cycle, with that source's index. The pulse lasts one cycle unless the next consume also hits a flagged source.
- R7: A speculative consume never gives a deferred pulse, even when its sources are flagged.
- R8: When both enabled sources of a non-speculative consume are flagged, the deferred index is the port A index.
- R9: When a read index equals the index of a committing write in the same cycle, the read returns the write's data and its new flag value. The deferred-exception check uses that bypassed flag.
- R10: Register 0 always reads data 0 with its flag clear. Writes to it are ignored.
- R11: A flagged source whose use enable is low causes no deferred pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_idx | input | IDX_W | Read port A register index |
| rd_a_data | output | DW | Read port A data (bypassed) |
| rd_a_poison | output | 1 | Read port A fault flag (bypassed) |
| rd_b_idx | input | IDX_W | Read port B register index |
| rd_b_data | output | DW | Read port B data (bypassed) |
| rd_b_poison | output | 1 | Read port B fault flag (bypassed) |
| use_valid | input | 1 | An instruction consumes the read ports this cycle |
| use_spec | input | 1 | The consuming instruction is speculative |
| use_a | input | 1 | Port A is a real source of the consumer |
| use_b | input | 1 | Port B is a real source of the consumer |
| wr_en | input | 1 | Write port valid |
| wr_idx | input | IDX_W | Write destination index |
| wr_data | input | DW | Write data |
| wr_spec | input | 1 | The writing instruction is speculative |
| wr_fault | input | 1 | The writing instruction hit an exception |
| wr_taint | input | 1 | A source of the writing instruction was flagged |
| defer_exc | output | 1 | Deferred-exception pulse |
| defer_idx | output | IDX_W | Register index of the flagged source |
| trap_exc | output | 1 | Immediate-trap pulse for a non-speculative fault |
| trap_idx | output | IDX_W | Destination index of the faulting write |

## Verification
The hardest case to reach from the ports is a single cycle in which a write and a consume meet on the same register and the write changes that register's flag. The deferred pulse then depends on the bypassed flag, not the stored one. The bench first flags or clears selected registers. It then issues a write and a non-speculative consume to the same index in one cycle, in both directions: a clean write over a flagged register must suppress the pulse, and a faulting speculative write over a clean register must cause it. Dual-flag priority and disabled-source cases are set up the same way, by first building a known flag pattern across the register sweep.

// File: rtl/poison_rf_pkg.sv
package poison_rf_pkg;
  typedef struct packed {
    logic commit;  // register is updated
    logic poison;  // new flag value when committed
    logic trap;    // immediate trap request
  } wr_decision_t;
endpackage

// File: rtl/poison_rf_wr_ctl.sv
module poison_rf_wr_ctl
  import poison_rf_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic               wr_spec,
  input  logic               wr_fault,
  input  logic               wr_taint,
  output wr_decision_t       dec
);
  logic live;

  always_comb begin
    live       = wr_en && (wr_idx != '0);
    dec.commit = live && (wr_spec || !wr_fault);
    dec.poison = wr_spec && (wr_fault || wr_taint);
    dec.trap   = wr_en && !wr_spec && wr_fault;
  end
endmodule

// File: rtl/poison_rf_storage.sv
module poison_rf_storage #(
  parameter int NREGS = 32,
  parameter int DW    = 32,
  localparam int IDX_W = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic             poison,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DW-1:0]    wr_data,
  output logic [DW-1:0]    data_q [NREGS],
  output logic             pois_q [NREGS]
);
  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    if (i == 0) begin : g_zero
      assign data_q[i] = '0;
      assign pois_q[i] = 1'b0;
    end else begin : g_live
      logic          en;
      logic [DW-1:0] d_nx;
      logic          p_nx;

      always_comb begin
        en   = commit && (wr_idx == IDX_W'(i));
        d_nx = en ? wr_data : data_q[i];
        p_nx = en ? poison  : pois_q[i];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          data_q[i] <= '0;
          pois_q[i] <= 1'b0;
        end else if (en) begin
          data_q[i] <= d_nx;
          pois_q[i] <= p_nx;
        end
      end
    end
  end

  // R3: a clean commit leaves the destination unflagged
  p_clean_cures_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !poison) |=> !pois_q[$past(wr_idx)]);
endmodule

// File: rtl/poison_rf_read_port.sv
module poison_rf_read_port #(
  parameter int NREGS = 32,
  parameter int DW    = 32,
  localparam int IDX_W = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [DW-1:0]    data_q [NREGS],
  input  logic             pois_q [NREGS],
  input  logic             commit,
  input  logic             poison,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DW-1:0]    wr_data,
  output logic [DW-1:0]    rd_data,
  output logic             rd_poison
);
  logic hit;

  always_comb begin
    hit       = commit && (wr_idx == rd_idx);
    rd_data   = hit ? wr_data : data_q[rd_idx];
    rd_poison = hit ? poison  : pois_q[rd_idx];
  end

  // R10: register zero is always clean and zero at a read port
  p_zero_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx == '0) |-> (rd_data == '0 && !rd_poison));
endmodule

// File: rtl/poison_rf_exc.sv
module poison_rf_exc #(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             use_valid,
  input  logic             use_spec,
  input  logic             use_a,
  input  logic             use_b,
  input  logic [IDX_W-1:0] a_idx,
  input  logic [IDX_W-1:0] b_idx,
  input  logic             a_pois,
  input  logic             b_pois,
  input  logic             trap_req,
  input  logic [IDX_W-1:0] wr_idx,
  output logic             defer_exc,
  output logic [IDX_W-1:0] defer_idx,
  output logic             trap_exc,
  output logic [IDX_W-1:0] trap_idx
);
  logic             hit_a, hit_b, defer_d;
  logic [IDX_W-1:0] defer_idx_d;

  always_comb begin
    hit_a       = use_valid && !use_spec && use_a && a_pois;
    hit_b       = use_valid && !use_spec && use_b && b_pois;
    defer_d     = hit_a || hit_b;
    defer_idx_d = hit_a ? a_idx : b_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      defer_exc <= 1'b0;
      trap_exc  <= 1'b0;
    end else begin
      defer_exc <= defer_d;
      trap_exc  <= trap_req;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) defer_idx <= '0;
    else if (defer_d) defer_idx <= defer_idx_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trap_idx <= '0;
    else if (trap_req) trap_idx <= wr_idx;
  end

  // R6: a deferred pulse only follows a non-speculative consume
  p_defer_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    defer_exc |-> $past(use_valid && !use_spec));
  // R7: speculative consumers stay silent
  p_spec_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (use_valid && use_spec) |=> !defer_exc);
  // R8: port A wins when it is flagged
  p_port_a_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (use_valid && !use_spec && use_a && a_pois) |=> (defer_exc && defer_idx == $past(a_idx)));
  // R11: no enabled source, no pulse
  p_unused_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (use_valid && !use_a && !use_b) |=> !defer_exc);
endmodule

// File: rtl/poison_regfile.sv
module poison_regfile
  import poison_rf_pkg::*;
#(
  parameter int NREGS = 32,
  parameter int DW    = 32,
  localparam int IDX_W = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_a_idx,
  output logic [DW-1:0]    rd_a_data,
  output logic             rd_a_poison,
  input  logic [IDX_W-1:0] rd_b_idx,
  output logic [DW-1:0]    rd_b_data,
  output logic             rd_b_poison,
  input  logic             use_valid,
  input  logic             use_spec,
  input  logic             use_a,
  input  logic             use_b,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DW-1:0]    wr_data,
  input  logic             wr_spec,
  input  logic             wr_fault,
  input  logic             wr_taint,
  output logic             defer_exc,
  output logic [IDX_W-1:0] defer_idx,
  output logic             trap_exc,
  output logic [IDX_W-1:0] trap_idx
);
  wr_decision_t  dec;
  logic [DW-1:0] data_q [NREGS];
  logic          pois_q [NREGS];
  logic [NREGS-1:0] pois_vec;

  poison_rf_wr_ctl #(.IDX_W(IDX_W)) u_wr_ctl (
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_spec(wr_spec),
    .wr_fault(wr_fault), .wr_taint(wr_taint), .dec(dec)
  );

  poison_rf_storage #(.NREGS(NREGS), .DW(DW)) u_storage (
    .clk(clk), .rst_n(rst_n), .commit(dec.commit), .poison(dec.poison),
    .wr_idx(wr_idx), .wr_data(wr_data), .data_q(data_q), .pois_q(pois_q)
  );

  logic [IDX_W-1:0] rp_idx  [2];
  logic [DW-1:0]    rp_data [2];
  logic             rp_pois [2];

  assign rp_idx[0]   = rd_a_idx;
  assign rp_idx[1]   = rd_b_idx;
  assign rd_a_data   = rp_data[0];
  assign rd_a_poison = rp_pois[0];
  assign rd_b_data   = rp_data[1];
  assign rd_b_poison = rp_pois[1];

  for (genvar p = 0; p < 2; p++) begin : g_rport
    poison_rf_read_port #(.NREGS(NREGS), .DW(DW)) u_rport (
      .clk(clk), .rst_n(rst_n), .rd_idx(rp_idx[p]),
      .data_q(data_q), .pois_q(pois_q),
      .commit(dec.commit), .poison(dec.poison),
      .wr_idx(wr_idx), .wr_data(wr_data),
      .rd_data(rp_data[p]), .rd_poison(rp_pois[p])
    );
  end

  poison_rf_exc #(.IDX_W(IDX_W)) u_exc (
    .clk(clk), .rst_n(rst_n),
    .use_valid(use_valid), .use_spec(use_spec), .use_a(use_a), .use_b(use_b),
    .a_idx(rd_a_idx), .b_idx(rd_b_idx),
    .a_pois(rp_pois[0]), .b_pois(rp_pois[1]),
    .trap_req(dec.trap), .wr_idx(wr_idx),
    .defer_exc(defer_exc), .defer_idx(defer_idx),
    .trap_exc(trap_exc), .trap_idx(trap_idx)
  );

  for (genvar i = 0; i < NREGS; i++) begin : g_pvec
    assign pois_vec[i] = pois_q[i];
  end

  // R5: a faulting non-speculative write leaves every flag unchanged
  p_trap_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trap_exc |-> $stable(pois_vec));
  // R2: a speculative fault flags its (non-zero) destination
  p_spec_fault_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_spec && wr_fault && wr_idx != '0) |=> pois_vec[$past(wr_idx)]);
endmodule

// File: tb/tb_poison_regfile.sv
`timescale 1ns/100ps
module tb_poison_regfile;
  localparam int NREGS = 16;
  localparam int DW    = 16;
  localparam int IDX_W = $clog2(NREGS);

  logic clk = 1'b0;
  logic rst_n;
  logic [IDX_W-1:0] rd_a_idx, rd_b_idx, wr_idx;
  logic [DW-1:0]    rd_a_data, rd_b_data, wr_data;
  logic rd_a_poison, rd_b_poison;
  logic use_valid, use_spec, use_a, use_b;
  logic wr_en, wr_spec, wr_fault, wr_taint;
  logic defer_exc, trap_exc;
  logic [IDX_W-1:0] defer_idx, trap_idx;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [DW-1:0] md [NREGS];
  logic          mp [NREGS];

  always #2 clk = ~clk;

  poison_regfile #(.NREGS(NREGS), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data), .rd_a_poison(rd_a_poison),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data), .rd_b_poison(rd_b_poison),
    .use_valid(use_valid), .use_spec(use_spec), .use_a(use_a), .use_b(use_b),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .wr_spec(wr_spec),
    .wr_fault(wr_fault), .wr_taint(wr_taint),
    .defer_exc(defer_exc), .defer_idx(defer_idx),
    .trap_exc(trap_exc), .trap_idx(trap_idx)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clr();
    use_valid = 0; use_spec = 0; use_a = 0; use_b = 0;
    wr_en = 0; wr_idx = '0; wr_data = '0; wr_spec = 0; wr_fault = 0; wr_taint = 0;
    rd_a_idx = '0; rd_b_idx = '0;
  endtask

  task automatic wr(input int idx, input logic [DW-1:0] d, input logic s, input logic f, input logic t);
    wr_en = 1; wr_idx = IDX_W'(idx); wr_data = d; wr_spec = s; wr_fault = f; wr_taint = t;
  endtask

  task automatic consume(input int a, input int b, input logic s, input logic ua, input logic ub);
    rd_a_idx = IDX_W'(a); rd_b_idx = IDX_W'(b);
    use_valid = 1; use_spec = s; use_a = ua; use_b = ub;
  endtask

  // model of one write, written from the requirements
  task automatic mw(input int idx, input logic [DW-1:0] d, input logic s, input logic f, input logic t);
    if (idx != 0 && (s || !f)) begin
      md[idx] = d;
      mp[idx] = s && (f || t);
    end
  endtask

  // advance one clock; return 0.5 ns after the edge with inputs cleared
  task automatic tick();
    @(posedge clk);
    #0.5;
    clr();
  endtask

  task automatic read_both(input int idx, input string req);
    rd_a_idx = IDX_W'(idx); rd_b_idx = IDX_W'(idx);
    #0.5;
    chk(req, rd_a_data, md[idx]);
    chk(req, rd_b_data, md[idx]);
    chk(req, rd_a_poison, mp[idx]);
    chk(req, rd_b_poison, mp[idx]);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    clr();
    rst_n = 0;
    for (int i = 0; i < NREGS; i++) begin md[i] = '0; mp[i] = 0; end
    #9.5 rst_n = 1;
    @(posedge clk); #0.5;

    // R1: reset state across the whole file
    for (int i = 0; i < NREGS; i++) begin
      rd_a_idx = IDX_W'(i); rd_b_idx = IDX_W'(NREGS - 1 - i);
      #0.5;
      chk("R1 data A", rd_a_data, 0); chk("R1 flag A", rd_a_poison, 0);
      chk("R1 data B", rd_b_data, 0); chk("R1 flag B", rd_b_poison, 0);
    end
    chk("R1 defer", defer_exc, 0);
    chk("R1 trap", trap_exc, 0);

    // R3: clean non-speculative writes to every register
    for (int i = 1; i < NREGS; i++) begin
      logic [DW-1:0] d = DW'(i * 16'h0101 ^ 16'h5a00);
      wr(i, d, 0, 0, 0); mw(i, d, 0, 0, 0);
      tick();
      read_both(i, "R3 clean write");
    end

    // R2: speculative faulting writes flag every register, no trap
    for (int i = 1; i < NREGS; i++) begin
      logic [DW-1:0] d = DW'(i * 7 + 3);
      wr(i, d, 1, 1, 0); mw(i, d, 1, 1, 0);
      tick();
      chk("R2 no trap", trap_exc, 0);
      read_both(i, "R2 spec fault flags");
    end

    // R6: non-speculative consume of each flagged register
    for (int i = 1; i < NREGS; i++) begin
      consume(i, 0, 0, 1, 1);
      tick();
      chk("R6 defer pulse", defer_exc, 1);
      chk("R6 defer idx", defer_idx, i);
      tick();
      chk("R6 pulse ends", defer_exc, 0);
    end

    // R7: speculative consume of flagged sources is silent
    for (int i = 1; i < NREGS; i++) begin
      consume(i, NREGS - i, 1, 1, 1);
      tick();
      chk("R7 spec consume quiet", defer_exc, 0);
    end

    // R8: both sources flagged, port A reported
    consume(3, 5, 0, 1, 1); tick();
    chk("R8 both flagged", defer_idx, 3); chk("R8 pulse", defer_exc, 1);
    consume(9, 2, 0, 1, 1); tick();
    chk("R8 both flagged high A", defer_idx, 9);

    // R11: disabled source ignored
    consume(4, 6, 0, 0, 1); tick();
    chk("R11 B reported when A disabled", defer_idx, 6); chk("R11 pulse", defer_exc, 1);
    consume(4, 6, 0, 0, 0); tick();
    chk("R11 none enabled", defer_exc, 0);

    // R3: speculative clean write cures a flagged register
    wr(3, 16'h1234, 1, 0, 0); mw(3, 16'h1234, 1, 0, 0); tick();
    read_both(3, "R3 spec clean cures");
    consume(3, 0, 0, 1, 0); tick();
    chk("R3 cured no defer", defer_exc, 0);

    // R4: taint propagation onto a clean register
    wr(8, 16'h0f0f, 0, 0, 0); mw(8, 16'h0f0f, 0, 0, 0); tick();
    wr(8, 16'h7777, 1, 0, 1); mw(8, 16'h7777, 1, 0, 1); tick();
    chk("R4 no trap", trap_exc, 0); chk("R4 no defer", defer_exc, 0);
    read_both(8, "R4 taint flags");

    // R5: non-speculative fault traps and changes nothing
    wr(3, 16'hdead, 0, 1, 0); mw(3, 16'hdead, 0, 1, 0); tick();
    chk("R5 trap pulse", trap_exc, 1); chk("R5 trap idx", trap_idx, 3);
    read_both(3, "R5 register unchanged");
    tick();
    chk("R5 trap one cycle", trap_exc, 0);
    wr(0, 16'hbeef, 0, 1, 0); tick();
    chk("R5 trap on reg0 write", trap_exc, 1); chk("R5 trap idx 0", trap_idx, 0);

    // R9: bypass, clean write over flagged reg 6 hides the old flag
    wr(6, 16'hcafe, 1, 0, 0); consume(6, 6, 0, 1, 1);
    #0.5;
    chk("R9 bypass data A", rd_a_data, 16'hcafe); chk("R9 bypass data B", rd_b_data, 16'hcafe);
    chk("R9 bypass flag clear", rd_a_poison, 0);
    mw(6, 16'hcafe, 1, 0, 0); tick();
    chk("R9 no defer via bypass", defer_exc, 0);
    // R9: faulting speculative write over clean reg 3 is seen by consumer
    wr(3, 16'h4321, 1, 1, 0); consume(0, 3, 0, 1, 1);
    #0.5;
    chk("R9 bypass flag set", rd_b_poison, 1);
    mw(3, 16'h4321, 1, 1, 0); tick();
    chk("R9 defer via bypass", defer_exc, 1); chk("R9 defer idx", defer_idx, 3);

    // R10: register zero stays clean
    wr(0, 16'hffff, 1, 1, 0); consume(0, 0, 0, 1, 1);
    #0.5;
    chk("R10 bypass excluded", rd_a_data, 0); chk("R10 flag", rd_a_poison, 0);
    tick();
    chk("R10 no defer", defer_exc, 0);
    wr(0, 16'hffff, 0, 0, 0); tick();
    read_both(0, "R10 write ignored");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule